// File: doc/BRIEF.md
# Double-Buffered Sliced-Text Line Buffer

This block sits between a vertical-blanking data slicer and a shared byte-wide output port. Slicer bytes are written into one of two line-sized storage halves. A half is offered to the output side only after its line has been closed, so a partially captured line is never visible to the consumer. While one finished line waits for, or is being sent in, an output burst, the next line fills the other half.

When the external arbiter grants the request, the block sends the whole line as one gap-free burst. The qualifier is high on every byte. Each burst starts with a six-byte header. Its style is set by a 6-bit identifier setting: either an ancillary-data prefix carrying that identifier, or a timing-code prefix. The header carries the captured line number, the video standard code and a word count. Payload bytes may be recoded so that the reserved values 00h and FFh never appear. A sliced-data flag rises with the first header byte. It stays high across any number of bursts and falls only when the video path reports a start-of-active-video code. Outside bursts the bus carries 00h.

Top module: `text_line_buffer`

## Requirements
- R1: After reset, outReq, outDq, outSliced and overflow are 0 and outData is 00h.
- R2: outReq stays low while a line is still being captured and rises only after lineEnd closes a line in a free half.
- R3: Two cycles after outGrant is sampled high with outReq, outDq is high for exactly 6 + L consecutive cycles, where L is the stored payload length.
- R4: When didSel < 3Eh, the header is 00h, FFh, FFh, {2'b00, didSel}, lineNum, {stdCode, count}. Here count is floor(L/4) in 6 bits, and lineNum and stdCode are the values sampled with lineStart.
- R5: When didSel is 3Eh or 3Fh, the header is FFh, 00h, 00h, B6h, lineNum, {stdCode, count}.
- R6: With recodeEn = 1, a payload byte 00h is sent as 03h and FFh as FCh. With recodeEn = 0, payload bytes are sent unchanged. Header bytes are never recoded.
- R7: outSliced goes high in the cycle of the first header byte and stays high across later bursts until a videoSav pulse clears it. outDq is never high while outSliced is low.
- R8: Two lines can be held at once, and they are sent in the order they were captured.
- R9: A lineStart while both halves hold unsent lines drops that whole line and sets overflow. overflow stays set until reset.
- R10: A half stores at most 64 payload bytes. Bytes beyond that are discarded, and the stored length is taken at lineEnd.
- R11: outData is 00h in every cycle in which outDq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Slicer byte strobe |
| wrData | input | 8 | Slicer byte |
| lineStart | input | 1 | Opens a new line; a byte in the same cycle is ignored |
| lineEnd | input | 1 | Closes the current line; a byte in the same cycle is kept |
| lineNum | input | 8 | Line number, sampled with lineStart |
| stdCode | input | 2 | Video standard code, sampled with lineStart |
| didSel | input | 6 | Header style and identifier |
| recodeEn | input | 1 | Enables payload recoding |
| outGrant | input | 1 | Arbiter grant; starts a burst when outReq is high |
| videoSav | input | 1 | Pulse when the video path emits a start-of-active-video code |
| outReq | output | 1 | A complete line is ready to send |
| outData | output | 8 | Output byte |
| outDq | output | 1 | Data qualifier |
| outSliced | output | 1 | Sliced-data framing flag |
| overflow | output | 1 | Sticky line-drop indicator |

## Verification
The assertions assume several things about the inputs. lineEnd only follows a lineStart. outGrant is a single-cycle pulse given while outReq is high. didSel and recodeEn are held steady for the length of a burst. The directed stimulus changes didSel and recodeEn only between bursts and gives each grant for exactly one cycle after seeing outReq. The bench also exercises a third line arriving while both halves are full, and a line longer than one half.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int LINE_BYTES = 64;
  localparam int HDR_BYTES  = 6;
  localparam int ADDR_W     = $clog2(LINE_BYTES);
  localparam int PTR_W      = $clog2(LINE_BYTES + 1);
  localparam int IDX_W      = $clog2(LINE_BYTES + HDR_BYTES);

  typedef struct packed {
    logic              wrEn;
    logic              wrSec;
    logic [ADDR_W-1:0] wrAddr;
    logic              oEn;
    logic              rdSec;
    logic [IDX_W-1:0]  oIdx;
    logic [7:0]        hdrLine;
    logic [1:0]        hdrStd;
    logic [PTR_W-1:0]  hdrLen;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       lineStart,
  input  logic       lineEnd,
  input  logic [7:0] lineNum,
  input  logic [1:0] stdCode,
  input  logic       outGrant,
  output logic       outReq,
  output logic       overflow,
  output tlbStrobe_t strb
);
  localparam logic [PTR_W-1:0] FULL_LEN = PTR_W'(LINE_BYTES);

  logic             collecting, wrSel, rdSel, busy;
  logic [PTR_W-1:0] wrPtr;
  logic [IDX_W-1:0] idx, lastIdx;
  logic [1:0]       secFull;
  logic [PTR_W-1:0] secLen  [2];
  logic [7:0]       secLine [2];
  logic [1:0]       secStd  [2];
  logic             accept;

  assign accept  = collecting && wrValid && !lineStart && (wrPtr < FULL_LEN);
  assign outReq  = secFull[rdSel] && !busy;
  assign lastIdx = IDX_W'(HDR_BYTES - 1) + IDX_W'(secLen[rdSel]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      collecting <= 1'b0;
      wrSel      <= 1'b0;
      wrPtr      <= '0;
      overflow   <= 1'b0;
      rdSel      <= 1'b0;
      busy       <= 1'b0;
      idx        <= '0;
      secFull    <= '0;
      for (int s = 0; s < 2; s++) begin
        secLen[s]  <= '0;
        secLine[s] <= '0;
        secStd[s]  <= '0;
      end
    end else begin
      // capture side
      if (lineStart) begin
        if (secFull[wrSel]) begin
          collecting <= 1'b0;
          overflow   <= 1'b1;
        end else begin
          collecting     <= 1'b1;
          wrPtr          <= '0;
          secLine[wrSel] <= lineNum;
          secStd[wrSel]  <= stdCode;
        end
      end else if (collecting && lineEnd) begin
        collecting     <= 1'b0;
        secLen[wrSel]  <= wrPtr + PTR_W'(accept);
        secFull[wrSel] <= 1'b1;
        wrSel          <= ~wrSel;
      end else if (accept) begin
        wrPtr <= wrPtr + 1'b1;
      end
      // burst side
      if (outReq && outGrant) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (idx == lastIdx) begin
          busy           <= 1'b0;
          secFull[rdSel] <= 1'b0;
          rdSel          <= ~rdSel;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.wrEn    = accept;
    strb.wrSec   = wrSel;
    strb.wrAddr  = wrPtr[ADDR_W-1:0];
    strb.oEn     = busy;
    strb.rdSec   = rdSel;
    strb.oIdx    = idx;
    strb.hdrLine = secLine[rdSel];
    strb.hdrStd  = secStd[rdSel];
    strb.hdrLen  = secLen[rdSel];
  end

  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> !secFull[wrSel]);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  // R3
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && idx != lastIdx) |=> busy);
  // R10
  len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= FULL_LEN);
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tlbStrobe_t strb,
  input  logic [7:0] wrData,
  input  logic [5:0] didSel,
  input  logic       recodeEn,
  input  logic       videoSav,
  output logic [7:0] outData,
  output logic       outDq,
  output logic       outSliced
);
  localparam logic [5:0] FIRST_CODE_DID = 6'h3E;
  localparam logic [7:0] TIMING_WORD    = 8'hB6;

  logic [7:0]        mem [2][LINE_BYTES];
  logic [ADDR_W-1:0] payIdx;
  logic [7:0]        rawByte, payByte, hdrByte, nextByte;
  logic [5:0]        cnt;
  logic              ancMode, inHdr;

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[strb.wrSec][strb.wrAddr] <= wrData;
  end

  assign payIdx  = ADDR_W'(strb.oIdx - IDX_W'(HDR_BYTES));
  assign rawByte = mem[strb.rdSec][payIdx];
  assign ancMode = didSel < FIRST_CODE_DID;
  assign inHdr   = strb.oIdx < IDX_W'(HDR_BYTES);
  assign cnt     = 6'(strb.hdrLen >> 2);

  always_comb begin
    payByte = rawByte;
    if (recodeEn && rawByte == 8'h00) payByte = 8'h03;
    if (recodeEn && rawByte == 8'hFF) payByte = 8'hFC;
    case (strb.oIdx[2:0])
      3'd0:    hdrByte = ancMode ? 8'h00 : 8'hFF;
      3'd1,
      3'd2:    hdrByte = ancMode ? 8'hFF : 8'h00;
      3'd3:    hdrByte = ancMode ? {2'b00, didSel} : TIMING_WORD;
      3'd4:    hdrByte = strb.hdrLine;
      default: hdrByte = {strb.hdrStd, cnt};
    endcase
    nextByte = !strb.oEn ? 8'h00 : (inHdr ? hdrByte : payByte);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= 8'h00;
      outDq     <= 1'b0;
      outSliced <= 1'b0;
    end else begin
      outData <= nextByte;
      outDq   <= strb.oEn;
      if (strb.oEn && strb.oIdx == '0) outSliced <= 1'b1;
      else if (videoSav)               outSliced <= 1'b0;
    end
  end

  // R7
  dq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outDq |-> outSliced);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSliced && !videoSav) |=> outSliced);
  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outDq |-> outData == 8'h00);
endmodule

// File: rtl/text_line_buffer.sv
module text_line_buffer
  import tlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       lineStart,
  input  logic       lineEnd,
  input  logic [7:0] lineNum,
  input  logic [1:0] stdCode,
  input  logic [5:0] didSel,
  input  logic       recodeEn,
  input  logic       outGrant,
  input  logic       videoSav,
  output logic       outReq,
  output logic [7:0] outData,
  output logic       outDq,
  output logic       outSliced,
  output logic       overflow
);
  tlbStrobe_t strb;

  tlb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .lineStart(lineStart),
    .lineEnd(lineEnd), .lineNum(lineNum), .stdCode(stdCode),
    .outGrant(outGrant), .outReq(outReq), .overflow(overflow), .strb(strb)
  );

  tlb_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .didSel(didSel),
    .recodeEn(recodeEn), .videoSav(videoSav), .outData(outData),
    .outDq(outDq), .outSliced(outSliced)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outDq && !outSliced && !overflow));
endmodule

// File: tb/text_line_buffer_tb.sv
module text_line_buffer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrValid = 1'b0, lineStart = 1'b0, lineEnd = 1'b0;
  logic [7:0] wrData = '0, lineNum = '0;
  logic [1:0] stdCode = '0;
  logic [5:0] didSel = '0;
  logic       recodeEn = 1'b0, outGrant = 1'b0, videoSav = 1'b0;
  logic       outReq, outDq, outSliced, overflow;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  text_line_buffer u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    if (i % 5 == 0)      return 8'h00;
    else if (i % 5 == 1) return 8'hFF;
    else                 return seed + 8'(i);
  endfunction

  task automatic writeLine(input logic [7:0] seed, input int len,
                           input logic [7:0] ln, input logic [1:0] sc,
                           input bit checkPartial);
    @(negedge clk);
    lineStart = 1'b1; lineNum = ln; stdCode = sc;
    @(negedge clk);
    lineStart = 1'b0;
    for (int i = 0; i < len; i++) begin
      wrValid = 1'b1; wrData = pat(seed, i);
      @(negedge clk);
    end
    wrValid = 1'b0;
    if (checkPartial) chk("R2 no request on partial line", outReq, 0);
    lineEnd = 1'b1;
    @(negedge clk);
    lineEnd = 1'b0;
  endtask

  task automatic readLine(input logic [7:0] seed, input int len,
                          input logic [7:0] ln, input logic [1:0] sc);
    int stored, k, wait_n;
    bit anc;
    logic [7:0] exp [6];
    logic [7:0] b;
    stored = (len > 64) ? 64 : len;
    anc = didSel < 6'h3E;
    exp[0] = anc ? 8'h00 : 8'hFF;
    exp[1] = anc ? 8'hFF : 8'h00;
    exp[2] = exp[1];
    exp[3] = anc ? {2'b00, didSel} : 8'hB6;
    exp[4] = ln;
    exp[5] = {sc, 6'(stored / 4)};
    wait_n = 0;
    while (!outReq && wait_n < 50) begin @(negedge clk); wait_n++; end
    chk("R2 request after line closed", outReq, 1);
    outGrant = 1'b1;
    @(negedge clk);
    outGrant = 1'b0;
    chk("R3 qualifier low one cycle after grant", outDq, 0);
    @(negedge clk);
    k = 0;
    while (outDq && k < 200) begin
      chk("R7 flag high during burst", outSliced, 1);
      if (k < 6) chk(anc ? "R4 ancillary header" : "R5 timing header", outData, exp[k]);
      else begin
        b = pat(seed, k - 6);
        if (recodeEn && b == 8'h00) b = 8'h03;
        if (recodeEn && b == 8'hFF) b = 8'hFC;
        chk("R6 payload byte", outData, b);
      end
      k++;
      @(negedge clk);
    end
    chk("R3 contiguous burst length", k, 6 + stored);
    chk("R11 idle bus zero", outData, 0);
  endtask

  task automatic t_reset();
    chk("R1 outReq", outReq, 0);
    chk("R1 outDq", outDq, 0);
    chk("R1 outSliced", outSliced, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 outData", outData, 0);
  endtask

  task automatic t_anc_recode();
    didSel = 6'h15; recodeEn = 1'b1;
    writeLine(8'h20, 10, 8'h2A, 2'd1, 1'b1);
    readLine(8'h20, 10, 8'h2A, 2'd1);
    chk("R2 request dropped after burst", outReq, 0);
  endtask

  task automatic t_timing_flag();
    didSel = 6'h3F; recodeEn = 1'b0;
    writeLine(8'h40, 8, 8'h11, 2'd2, 1'b1);
    chk("R7 flag spans lines", outSliced, 1);
    readLine(8'h40, 8, 8'h11, 2'd2);
    repeat (3) @(negedge clk);
    chk("R7 flag held without video code", outSliced, 1);
    videoSav = 1'b1;
    @(negedge clk);
    videoSav = 1'b0;
    chk("R7 flag cleared by video code", outSliced, 0);
  endtask

  task automatic t_double_overflow();
    didSel = 6'h05; recodeEn = 1'b1;
    writeLine(8'h60, 12, 8'h31, 2'd0, 1'b0);
    writeLine(8'h80, 5, 8'h32, 2'd3, 1'b0);
    chk("R9 no overflow with one free half", overflow, 0);
    writeLine(8'hA0, 6, 8'h33, 2'd1, 1'b0);
    chk("R9 overflow set on third line", overflow, 1);
    readLine(8'h60, 12, 8'h31, 2'd0);
    readLine(8'h80, 5, 8'h32, 2'd3);
    repeat (3) @(negedge clk);
    chk("R8 dropped line never offered", outReq, 0);
    chk("R9 overflow sticky", overflow, 1);
  endtask

  task automatic t_long_line();
    didSel = 6'h3E; recodeEn = 1'b0;
    writeLine(8'h10, 70, 8'h44, 2'd2, 1'b0);
    readLine(8'h10, 70, 8'h44, 2'd2);
    chk("R10 idle after truncated line", outReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_anc_recode();
    t_timing_flag();
    t_double_overflow();
    t_long_line();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule